// File: doc/BRIEF.md
# Trigger Accept Veto with Deglitched Busy Aggregation

This block sits between a trigger source and the readout boards that consume level-1 accepts. Each readout board or crate drives an asynchronous busy line. The block synchronizes every line, drops the lines that an enable mask excludes, and ORs the rest into a single busy flag. While that flag is up, no accept reaches the output. Busy rises on the first synchronized cycle in which any enabled line is high. It falls only after the OR has stayed low for a configurable run of consecutive clocks. A short low dip caused by a glitch therefore cannot open a window in which an accept passes.

The accept can come from one of two places. In master mode the block forwards requests from a local generator. In slave mode it forwards requests that arrive from further up the trigger chain. Every request is counted either as passed or as vetoed. A small registered read port returns both counters and a live status word. The read path is fully separate from the busy and accept logic, so a read cannot disturb either output.

Top module: `trig_busy_veto`

## Requirements
- R1: An enabled busy input that is high when sampled at clock edge k drives busy_o high after edge k+2. This is the two-flop synchronizer latency. There is no further filtering on the rising side.
- R2: When busy_en bit i is 0, busy_in bit i has no effect on busy_o, on accept_o, or on the veto counter.
- R3: After the masked OR of the synchronized inputs goes low, busy_o stays high for HOLD_LOW further edges. A low stretch shorter than HOLD_LOW edges never lowers busy_o. The default HOLD_LOW is 4.
- R4: accept_o is a registered single-cycle pulse. It is high after edge k exactly when the selected request was high and busy_o was low in the cycle before edge k.
- R5: When master_mode_i is 1, local_accept_i is the request and upstream_accept_i is ignored. When master_mode_i is 0, the roles are reversed.
- R6: The passed counter (CNT_W bits, wrapping) increments on each edge that produces an accept_o pulse. It is read at address 0.
- R7: The vetoed counter (CNT_W bits, wrapping) increments on each edge at which the selected request was high while busy_o was high. It is read at address 1.
- R8: Read data is registered. It is loaded on the edge at which reg_rd_i is high, from reg_addr_i: 0 gives passed, 1 gives vetoed, 2 gives status, and 3 gives zero. The status word holds the masked synchronized busy vector in bits NUM_IN-1:0 and busy_o in bit NUM_IN, with zeros above. reg_rdata_o holds its value while reg_rd_i is low.
- R9: Reads at any address and in any cycle do not change busy_o or accept_o.
- R10: A synchronous active-high reset clears busy_o, accept_o, both counters and reg_rdata_o. After reset, busy is released rather than held.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| busy_in | input | NUM_IN | Asynchronous busy lines, one per board |
| busy_en | input | NUM_IN | Per-line enable mask; 0 excludes the line |
| master_mode_i | input | 1 | 1 selects the local request, 0 selects the upstream request |
| local_accept_i | input | 1 | Accept request from the local generator |
| upstream_accept_i | input | 1 | Accept request from the upstream chain |
| reg_rd_i | input | 1 | Read strobe |
| reg_addr_i | input | 2 | Read address |
| accept_o | output | 1 | Gated accept pulse |
| busy_o | output | 1 | Aggregated, filtered busy |
| reg_rdata_o | output | CNT_W | Registered read data |

## Verification
Four properties are checked on every cycle. An accept never follows a busy cycle. An accept always traces back to the selected request. Busy never falls before the masked OR has been low for the hold count. The passed and vetoed counters move only together with an accept or with a busy request. The checker also holds that an enabled busy line that stays up reaches busy_o two edges later, and that read data is stable when no read is made. The bench scenarios are needed for the rest: masked-line exclusion, short low dips and edge-straddling spikes during a busy period, mode swapping with traffic on the unselected source, and the exact counter and status values returned through the read port.

// File: rtl/busy_veto_pkg.sv
package busy_veto_pkg;

    typedef enum logic [1:0] {
        RSEL_PASSED = 2'd0,
        RSEL_VETOED = 2'd1,
        RSEL_STATUS = 2'd2,
        RSEL_NONE   = 2'd3
    } rsel_e;

    typedef enum logic {
        SRC_UPSTREAM = 1'b0,
        SRC_LOCAL    = 1'b1
    } src_e;

    typedef struct packed {
        logic passed;
        logic vetoed;
    } gate_evt_t;

    function automatic logic pick_request(src_e src, logic loc, logic up);
        return (src == SRC_LOCAL) ? loc : up;
    endfunction

endpackage

// File: rtl/busy_in_sync.sv
module busy_in_sync #(
    parameter int NUM_IN = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [NUM_IN-1:0] async_i,
    output logic [NUM_IN-1:0] sync_o
);
    for (genvar g = 0; g < NUM_IN; g++) begin : g_line
        logic [1:0] stages;
        always_ff @(posedge clk) begin
            if (rst) stages <= 2'b00;
            else     stages <= {stages[0], async_i[g]};
        end
        assign sync_o[g] = stages[1];
    end
endmodule

// File: rtl/busy_hold_filter.sv
module busy_hold_filter #(
    parameter int HOLD_LOW = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic raw_i,
    output logic busy_o
);
    localparam int CW = $clog2(HOLD_LOW + 1);
    localparam logic [CW-1:0] LAST = CW'(HOLD_LOW - 1);

    logic          held_q;
    logic [CW-1:0] low_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            held_q <= 1'b0;
            low_q  <= '0;
        end else if (raw_i) begin
            held_q <= 1'b1;
            low_q  <= '0;
        end else if (held_q) begin
            if (low_q == LAST) begin
                held_q <= 1'b0;
                low_q  <= '0;
            end else begin
                low_q <= low_q + CW'(1);
            end
        end
    end

    // rising side is immediate, falling side waits for the run of lows
    assign busy_o = raw_i | held_q;
endmodule

// File: rtl/accept_gate.sv
module accept_gate
    import busy_veto_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  src_e      src_i,
    input  logic      loc_i,
    input  logic      up_i,
    input  logic      busy_i,
    output logic      accept_o,
    output gate_evt_t evt_o
);
    logic req;
    logic accept_q;

    assign req          = pick_request(src_i, loc_i, up_i);
    assign evt_o.passed = req & ~busy_i;
    assign evt_o.vetoed = req &  busy_i;

    always_ff @(posedge clk) begin
        if (rst) accept_q <= 1'b0;
        else     accept_q <= evt_o.passed;
    end

    assign accept_o = accept_q;
endmodule

// File: rtl/event_counters.sv
module event_counters
    import busy_veto_pkg::*;
#(
    parameter int CNT_W  = 32,
    parameter int STAT_W = 5
) (
    input  logic              clk,
    input  logic              rst,
    input  gate_evt_t         evt_i,
    input  logic              rd_i,
    input  rsel_e             sel_i,
    input  logic [STAT_W-1:0] status_i,
    output logic [CNT_W-1:0]  rdata_o,
    output logic [CNT_W-1:0]  passed_cnt_o,
    output logic [CNT_W-1:0]  vetoed_cnt_o
);
    logic [CNT_W-1:0] passed_q, vetoed_q, rdata_q, rd_mux, stat_ext;

    assign stat_ext = {{(CNT_W-STAT_W){1'b0}}, status_i};

    always_ff @(posedge clk) begin
        if (rst) begin
            passed_q <= '0;
            vetoed_q <= '0;
        end else begin
            if (evt_i.passed) passed_q <= passed_q + CNT_W'(1);
            if (evt_i.vetoed) vetoed_q <= vetoed_q + CNT_W'(1);
        end
    end

    always_comb begin
        unique case (sel_i)
            RSEL_PASSED: rd_mux = passed_q;
            RSEL_VETOED: rd_mux = vetoed_q;
            RSEL_STATUS: rd_mux = stat_ext;
            default:     rd_mux = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst)       rdata_q <= '0;
        else if (rd_i) rdata_q <= rd_mux;
    end

    assign rdata_o      = rdata_q;
    assign passed_cnt_o = passed_q;
    assign vetoed_cnt_o = vetoed_q;
endmodule

// File: rtl/trig_busy_veto.sv
module trig_busy_veto
    import busy_veto_pkg::*;
#(
    parameter int NUM_IN   = 4,
    parameter int HOLD_LOW = 4,
    parameter int CNT_W    = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [NUM_IN-1:0] busy_in,
    input  logic [NUM_IN-1:0] busy_en,
    input  logic              master_mode_i,
    input  logic              local_accept_i,
    input  logic              upstream_accept_i,
    input  logic              reg_rd_i,
    input  logic [1:0]        reg_addr_i,
    output logic              accept_o,
    output logic              busy_o,
    output logic [CNT_W-1:0]  reg_rdata_o
);
    localparam int STAT_W = NUM_IN + 1;

    logic [NUM_IN-1:0] busy_sync;
    logic [NUM_IN-1:0] busy_masked;
    logic              masked_or;
    logic              busy_eff;
    gate_evt_t         gate_evt;
    logic [CNT_W-1:0]  pass_cnt;
    logic [CNT_W-1:0]  veto_cnt;

    busy_in_sync #(.NUM_IN(NUM_IN)) u_sync (
        .clk     (clk),
        .rst     (rst),
        .async_i (busy_in),
        .sync_o  (busy_sync)
    );

    assign busy_masked = busy_sync & busy_en;
    assign masked_or   = |busy_masked;

    busy_hold_filter #(.HOLD_LOW(HOLD_LOW)) u_hold (
        .clk    (clk),
        .rst    (rst),
        .raw_i  (masked_or),
        .busy_o (busy_eff)
    );

    accept_gate u_gate (
        .clk      (clk),
        .rst      (rst),
        .src_i    (src_e'(master_mode_i)),
        .loc_i    (local_accept_i),
        .up_i     (upstream_accept_i),
        .busy_i   (busy_eff),
        .accept_o (accept_o),
        .evt_o    (gate_evt)
    );

    event_counters #(.CNT_W(CNT_W), .STAT_W(STAT_W)) u_cnt (
        .clk          (clk),
        .rst          (rst),
        .evt_i        (gate_evt),
        .rd_i         (reg_rd_i),
        .sel_i        (rsel_e'(reg_addr_i)),
        .status_i     ({busy_eff, busy_masked}),
        .rdata_o      (reg_rdata_o),
        .passed_cnt_o (pass_cnt),
        .vetoed_cnt_o (veto_cnt)
    );

    assign busy_o = busy_eff;
endmodule

// File: rtl/busy_veto_checker.sv
module busy_veto_checker #(
    parameter int NUM_IN   = 4,
    parameter int HOLD_LOW = 4,
    parameter int CNT_W    = 32
) (
    input logic              clk,
    input logic              rst,
    input logic [NUM_IN-1:0] busy_in,
    input logic [NUM_IN-1:0] busy_en,
    input logic [NUM_IN-1:0] busy_masked,
    input logic              master_mode_i,
    input logic              local_accept_i,
    input logic              upstream_accept_i,
    input logic              reg_rd_i,
    input logic              accept_o,
    input logic              busy_o,
    input logic [CNT_W-1:0]  reg_rdata_o,
    input logic [CNT_W-1:0]  pass_cnt,
    input logic [CNT_W-1:0]  veto_cnt
);
    int run_q;

    always_ff @(posedge clk) begin
        if (rst)                run_q <= HOLD_LOW;
        else if (|busy_masked)  run_q <= 0;
        else if (run_q < HOLD_LOW) run_q <= run_q + 1;
    end

    assert_latency_R1: assert property (@(posedge clk) disable iff (rst)
        (|(busy_in & busy_en)) ##1 $stable(busy_en) ##1 $stable(busy_en) |-> busy_o);

    assert_hold_release_R3: assert property (@(posedge clk) disable iff (rst)
        $fell(busy_o) |-> run_q >= HOLD_LOW);

    assert_no_accept_in_busy_R4: assert property (@(posedge clk) disable iff (rst)
        accept_o |-> !$past(busy_o));

    assert_source_select_R5: assert property (@(posedge clk) disable iff (rst)
        accept_o |-> $past(master_mode_i ? local_accept_i : upstream_accept_i));

    assert_pass_count_R6: assert property (@(posedge clk) disable iff (rst)
        (pass_cnt != $past(pass_cnt)) |-> accept_o);

    assert_veto_count_R7: assert property (@(posedge clk) disable iff (rst)
        (veto_cnt != $past(veto_cnt)) |-> $past(busy_o));

    assert_read_hold_R8: assert property (@(posedge clk) disable iff (rst)
        !reg_rd_i |=> $stable(reg_rdata_o));
endmodule

bind trig_busy_veto busy_veto_checker #(
    .NUM_IN(NUM_IN), .HOLD_LOW(HOLD_LOW), .CNT_W(CNT_W)
) u_chk (
    .clk               (clk),
    .rst               (rst),
    .busy_in           (busy_in),
    .busy_en           (busy_en),
    .busy_masked       (busy_masked),
    .master_mode_i     (master_mode_i),
    .local_accept_i    (local_accept_i),
    .upstream_accept_i (upstream_accept_i),
    .reg_rd_i          (reg_rd_i),
    .accept_o          (accept_o),
    .busy_o            (busy_o),
    .reg_rdata_o       (reg_rdata_o),
    .pass_cnt          (pass_cnt),
    .veto_cnt          (veto_cnt)
);

// File: tb/trig_busy_veto_bench.sv
`timescale 1ns/1ps
module trig_busy_veto_bench;
    localparam int N    = 4;
    localparam int HOLD = 4;
    localparam int CW   = 32;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [N-1:0]  busy_in = '0;
    logic [N-1:0]  busy_en = '1;
    logic          master_mode_i = 1'b0;
    logic          local_accept_i = 1'b0;
    logic          upstream_accept_i = 1'b0;
    logic          reg_rd_i = 1'b0;
    logic [1:0]    reg_addr_i = 2'd0;
    logic          accept_o;
    logic          busy_o;
    logic [CW-1:0] reg_rdata_o;

    int tests = 0;
    int fails = 0;
    bit running = 1'b0;

    always #5 clk = ~clk;

    trig_busy_veto #(.NUM_IN(N), .HOLD_LOW(HOLD), .CNT_W(CW)) u_trig_busy_veto (
        .clk(clk), .rst(rst), .busy_in(busy_in), .busy_en(busy_en),
        .master_mode_i(master_mode_i), .local_accept_i(local_accept_i),
        .upstream_accept_i(upstream_accept_i), .reg_rd_i(reg_rd_i),
        .reg_addr_i(reg_addr_i), .accept_o(accept_o), .busy_o(busy_o),
        .reg_rdata_o(reg_rdata_o)
    );

    // behavioural reference: history queue of samples, run length of lows
    logic [N-1:0] hist[$];
    int           lowrun;
    int unsigned  pass_n, veto_n;
    logic         exp_acc;
    logic [CW-1:0] exp_rd;

    function automatic logic [N-1:0] synced();
        return (hist.size() >= 2) ? hist[hist.size()-2] : '0;
    endfunction

    function automatic logic model_busy();
        return (|(synced() & busy_en)) || (lowrun < HOLD);
    endfunction

    always @(posedge clk) begin : ref_model
        logic orr, bz, req;
        if (rst) begin
            hist.delete();
            lowrun  = HOLD;
            pass_n  = 0;
            veto_n  = 0;
            exp_acc = 1'b0;
            exp_rd  = '0;
        end else begin
            orr = |(synced() & busy_en);
            bz  = model_busy();
            req = master_mode_i ? local_accept_i : upstream_accept_i;
            if (reg_rd_i) begin
                case (reg_addr_i)
                    2'd0: exp_rd = pass_n;
                    2'd1: exp_rd = veto_n;
                    2'd2: begin
                        exp_rd = '0;
                        exp_rd[N-1:0] = synced() & busy_en;
                        exp_rd[N] = bz;
                    end
                    default: exp_rd = '0;
                endcase
            end
            exp_acc = req && !bz;
            if (req && !bz) pass_n++;
            if (req && bz)  veto_n++;
            if (orr) lowrun = 0;
            else if (lowrun < HOLD) lowrun++;
            hist.push_back(busy_in);
            if (hist.size() > 2) void'(hist.pop_front());
        end
    end

    task automatic check(input string tag, input logic [CW-1:0] act, input logic [CW-1:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        if (running && !rst) begin
            check("R1 R3 busy_o vs model", CW'(busy_o), CW'(model_busy()));
            check("R4 R5 R9 accept_o vs model", CW'(accept_o), CW'(exp_acc));
            check("R8 reg_rdata_o vs model", reg_rdata_o, exp_rd);
        end
    end

    task automatic step(input int n = 1);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            #1;
        end
    endtask

    task automatic read_reg(input logic [1:0] a);
        reg_addr_i = a;
        reg_rd_i   = 1'b1;
        step();
        reg_rd_i   = 1'b0;
    endtask

    initial begin : watchdog
        #(200000 * 10);
        fails++;
        tests++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin : stimulus
        step(3);
        // R10 reset state
        check("R10 busy_o in reset", CW'(busy_o), 0);
        check("R10 accept_o in reset", CW'(accept_o), 0);
        check("R10 rdata in reset", reg_rdata_o, 0);
        rst = 1'b0;
        running = 1'b1;
        step(2);
        check("R10 busy released after reset", CW'(busy_o), 0);

        // R4/R5 slave mode pass-through
        upstream_accept_i = 1'b1; step(); upstream_accept_i = 1'b0;
        check("R4 accept after upstream request", CW'(accept_o), 1);
        step();
        check("R4 accept is single pulse", CW'(accept_o), 0);

        // R1 latency
        busy_in[0] = 1'b1;
        @(negedge clk);
        check("R1 not yet busy after one edge", CW'(busy_o), 0);
        @(negedge clk);
        check("R1 busy after two edges", CW'(busy_o), 1);
        #1;
        // requests during busy, with reads interleaved (R7, R9)
        for (int i = 0; i < 6; i++) begin
            upstream_accept_i = i[0];
            reg_rd_i = 1'b1; reg_addr_i = 2'(i % 4);
            step();
        end
        upstream_accept_i = 1'b0; reg_rd_i = 1'b0;

        // R3 low dip shorter than hold
        busy_in[0] = 1'b0; step(2); busy_in[0] = 1'b1;
        for (int i = 0; i < 5; i++) begin
            check("R3 dip does not release busy", CW'(busy_o), 1);
            step();
        end
        read_reg(2'd2);
        check("R8 status while busy", reg_rdata_o, CW'(32'h11));

        // R3 release timing
        busy_in[0] = 1'b0;
        upstream_accept_i = 1'b1;
        for (int i = 0; i < 5; i++) begin
            @(negedge clk);
            check("R3 held during low run", CW'(busy_o), 1);
        end
        @(negedge clk);
        check("R3 released after hold count", CW'(busy_o), 0);
        #1;
        step(3);
        upstream_accept_i = 1'b0;
        step();

        // spike straddling an edge, and a spike between edges
        @(negedge clk); #4; busy_in[1] = 1'b1; #2; busy_in[1] = 1'b0;
        upstream_accept_i = 1'b1;
        step(8);
        @(negedge clk); #1; busy_in[1] = 1'b1; #2; busy_in[1] = 1'b0;
        step(4);
        upstream_accept_i = 1'b0;

        // R2 masked line
        busy_en = 4'b1011; busy_in[2] = 1'b1;
        step(4);
        check("R2 masked line keeps busy low", CW'(busy_o), 0);
        upstream_accept_i = 1'b1; step(); upstream_accept_i = 1'b0;
        check("R2 accept passes with masked busy", CW'(accept_o), 1);
        busy_en = '1;
        step(3);
        check("R2 unmasking exposes busy", CW'(busy_o), 1);
        busy_in[2] = 1'b0;
        step(8);

        // R5 master mode
        master_mode_i = 1'b1;
        upstream_accept_i = 1'b1; step(); upstream_accept_i = 1'b0;
        check("R5 upstream ignored in master mode", CW'(accept_o), 0);
        local_accept_i = 1'b1; step(); local_accept_i = 1'b0;
        check("R5 local forwarded in master mode", CW'(accept_o), 1);
        local_accept_i = 1'b1; upstream_accept_i = 1'b1;
        step(3);
        local_accept_i = 1'b0; upstream_accept_i = 1'b0;
        master_mode_i = 1'b0;
        local_accept_i = 1'b1; step(); local_accept_i = 1'b0;
        check("R5 local ignored in slave mode", CW'(accept_o), 0);
        step();

        // R6 R7 R8 counter reads
        read_reg(2'd0);
        check("R6 passed count", reg_rdata_o, CW'(pass_n));
        read_reg(2'd1);
        check("R7 vetoed count", reg_rdata_o, CW'(veto_n));
        read_reg(2'd3);
        check("R8 unused address reads zero", reg_rdata_o, 0);
        read_reg(2'd0);
        step(3);
        check("R8 rdata held without read", reg_rdata_o, CW'(pass_n));

        running = 1'b0;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule